// File: doc/BRIEF.md
# Event Transfer Channel

This block moves one datum per service request between memory locations. An interrupt controller uses it instead of a software handler. On a request, the channel reads from a source pointer and writes the value to a destination pointer. Both accesses use a plain request/acknowledge memory port. The channel then steps the pointers as the control word selects, counts the transfer down, and flags the end of the transfer block on one of two interrupt outputs.

Software sets up the channel through a small write port. That port selects one of five registers:
- the 16-bit control word
- the two 16-bit pointer offsets
- the two segment registers

The offsets form the low part of each memory address and the segments form the high part. Pointer stepping stays inside the offset, so a run of transfers never crosses into a neighbouring segment. The channel exports its link-enable bit and its priority level for the surrounding arbiter, but it does not act on them itself.

Top module: `evt_xfer_chan`

## Requirements
- R1: After reset the control word, both offsets and both segments are zero. `busy`, `memReq`, `intReq`, `eotOwn` and `eotSep` are all low.
- R2: Word mode (control bit 8 = 0) reads and writes 16 bits.
  - The address carries the offset with bit 0 forced to 0, with `memByteEn` = 2'b11.
  - The word read at the source is written unchanged to the destination.
- R3: Byte mode (control bit 8 = 1) moves 8 bits.
  - Offset bit 0 of the pointer in use picks the lane: 0 gives the low byte and `memByteEn` = 2'b01; 1 gives the high byte and 2'b10.
  - The source-lane byte is written on both halves of `memWdata`.
- R4: Control bits 10:9 select the pointer update after each transfer: 00 changes neither pointer, 01 changes only the destination, 10 only the source, and 11 both.
- R5: A selected pointer steps by 2 in word mode and by 1 in byte mode.
- R6: Pointer stepping wraps modulo 2^16 within the offset. The segment part of an address never changes except by a software write.
- R7: Every completed transfer lowers control bits 7:0 (the count) by exactly 1.
- R8: When a transfer brings the count to 0, exactly one end-of-transfer pulse follows, one cycle wide.
  - It appears on `eotOwn` when control bit 14 is 0 and on `eotSep` when it is 1.
  - No pulse follows while the count stays above 0.
- R9: A request arriving while the count is 0 starts no memory access and leaves all registers unchanged. It raises `intReq` for exactly one cycle.
- R10: `busy` is high from the cycle after an accepted request until the write is acknowledged.
  - Each transfer starts with a read.
  - Requests arriving while busy are ignored.
- R11: `linkEn` follows control bit 11 and `prioLevel` follows control bits 13:12.
- R12: A write on the configuration port loads one register selected by `cfgSel`:
  - 0: control word. Bit 15 is always stored as 0.
  - 1: source offset.
  - 2: destination offset.
  - 3: source segment, taken from the low bits of `cfgData`.
  - 4: destination segment, taken from the low bits of `cfgData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 3 | Register select for the configuration write |
| cfgData | input | 16 | Configuration write data |
| srvReq | input | 1 | Service request from the interrupt controller |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 for a write access, 0 for a read |
| memAddr | output | SEG_W+OFS_W | Byte address: segment then offset |
| memByteEn | output | 2 | Byte lane enables |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, valid with memAck |
| memAck | input | 1 | Access acknowledge |
| busy | output | 1 | Transfer in progress |
| intReq | output | 1 | Pass-on interrupt when the count is 0 |
| eotOwn | output | 1 | End-of-transfer pulse on the channel's own level |
| eotSep | output | 1 | End-of-transfer pulse on the dedicated output |
| linkEn | output | 1 | Channel link flag |
| prioLevel | output | 2 | Priority level field |
| ctrlWord | output | 16 | Current control word |
| srcAddr | output | SEG_W+OFS_W | Current source segment and offset |
| dstAddr | output | SEG_W+OFS_W | Current destination segment and offset |

## Verification
The bench builds the channel with a 4-bit segment and the default 16-bit offset. This gives a 20-bit address, so a segment bit sits directly above the offset carry. Wrap-around at offsets 0xFFFE and 0xFFFF can therefore show any carry leaking into the segment. With the full offset width kept, the modulo-2^16 stepping in word and byte mode is exercised exactly as specified.

// File: rtl/evt_xfer_pkg.sv
package evt_xfer_pkg;

  // control word field positions (decoded by neighbours, so fixed)
  localparam int CNT_W    = 8;
  localparam int BIT_BYTE = 8;
  localparam int BIT_INC0 = 9;
  localparam int BIT_INC1 = 10;
  localparam int BIT_LINK = 11;
  localparam int BIT_PRI0 = 12;
  localparam int BIT_EOP  = 14;

  // configuration register selects
  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_SOFS = 3'd1;
  localparam logic [2:0] SEL_DOFS = 3'd2;
  localparam logic [2:0] SEL_SSEG = 3'd3;
  localparam logic [2:0] SEL_DSEG = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic latchRd;   // capture read data
    logic finish;    // write acknowledged: step pointers, count down
    logic useDst;    // drive destination address
  } xferStrobe_t;

endpackage

// File: rtl/evt_xfer_dp.sv
module evt_xfer_dp
  import evt_xfer_pkg::*;
#(
  parameter int SEG_W = 8,
  parameter int OFS_W = 16,
  localparam int AW = SEG_W + OFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [2:0]        cfgSel,
  input  logic [15:0]       cfgData,
  input  xferStrobe_t       strb,
  input  logic [15:0]       memRdata,
  output logic [15:0]       ctrlWord,
  output logic [AW-1:0]     srcAddr,
  output logic [AW-1:0]     dstAddr,
  output logic [AW-1:0]     memAddr,
  output logic [15:0]       memWdata,
  output logic [1:0]        memByteEn,
  output logic              cntZero,
  output logic              cntOne
);

  logic [15:0]      ctrlQ;
  logic [OFS_W-1:0] srcOfsQ, dstOfsQ;
  logic [SEG_W-1:0] srcSegQ, dstSegQ;
  logic [15:0]      dataQ;

  logic             byteMode;
  logic [OFS_W-1:0] step;
  logic [OFS_W-1:0] curOfs;
  logic [SEG_W-1:0] curSeg;
  logic [7:0]       srcByte;

  assign byteMode = ctrlQ[BIT_BYTE];
  assign step     = byteMode ? OFS_W'(1) : OFS_W'(2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      srcOfsQ <= '0;
      dstOfsQ <= '0;
      srcSegQ <= '0;
      dstSegQ <= '0;
    end else if (cfgWe) begin
      case (cfgSel)
        SEL_CTRL: ctrlQ   <= {1'b0, cfgData[14:0]};
        SEL_SOFS: srcOfsQ <= cfgData[OFS_W-1:0];
        SEL_DOFS: dstOfsQ <= cfgData[OFS_W-1:0];
        SEL_SSEG: srcSegQ <= cfgData[SEG_W-1:0];
        SEL_DSEG: dstSegQ <= cfgData[SEG_W-1:0];
        default: ;
      endcase
    end else if (strb.finish) begin
      ctrlQ[CNT_W-1:0] <= ctrlQ[CNT_W-1:0] - CNT_W'(1);
      if (ctrlQ[BIT_INC1]) srcOfsQ <= srcOfsQ + step;
      if (ctrlQ[BIT_INC0]) dstOfsQ <= dstOfsQ + step;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             dataQ <= '0;
    else if (strb.latchRd) dataQ <= memRdata;
  end

  assign curOfs  = strb.useDst ? dstOfsQ : srcOfsQ;
  assign curSeg  = strb.useDst ? dstSegQ : srcSegQ;
  assign memAddr = {curSeg, curOfs[OFS_W-1:1], byteMode & curOfs[0]};

  assign srcByte   = srcOfsQ[0] ? dataQ[15:8] : dataQ[7:0];
  assign memWdata  = byteMode ? {srcByte, srcByte} : dataQ;
  assign memByteEn = !byteMode ? 2'b11 : (curOfs[0] ? 2'b10 : 2'b01);

  assign ctrlWord = ctrlQ;
  assign srcAddr  = {srcSegQ, srcOfsQ};
  assign dstAddr  = {dstSegQ, dstOfsQ};
  assign cntZero  = (ctrlQ[CNT_W-1:0] == '0);
  assign cntOne   = (ctrlQ[CNT_W-1:0] == CNT_W'(1));

endmodule

// File: rtl/evt_xfer_ctrl.sv
module evt_xfer_ctrl
  import evt_xfer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        srvReq,
  input  logic        memAck,
  input  logic        cntZero,
  input  logic        cntOne,
  input  logic        eopSel,
  output xferStrobe_t strb,
  output logic        memReq,
  output logic        memWe,
  output logic        busy,
  output logic        intReq,
  output logic        eotOwn,
  output logic        eotSep
);

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} xferState_e;
  xferState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE:  if (srvReq && !cntZero) stateD = ST_READ;
      ST_READ:  if (memAck) stateD = ST_WRITE;
      ST_WRITE: if (memAck) stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_comb begin
    strb.latchRd = (stateQ == ST_READ) && memAck;
    strb.finish  = (stateQ == ST_WRITE) && memAck;
    strb.useDst  = (stateQ == ST_WRITE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      intReq <= 1'b0;
      eotOwn <= 1'b0;
      eotSep <= 1'b0;
    end else begin
      stateQ <= stateD;
      intReq <= (stateQ == ST_IDLE) && srvReq && cntZero;
      eotOwn <= strb.finish && cntOne && !eopSel;
      eotSep <= strb.finish && cntOne && eopSel;
    end
  end

  assign memReq = (stateQ != ST_IDLE);
  assign memWe  = (stateQ == ST_WRITE);
  assign busy   = (stateQ != ST_IDLE);

endmodule

// File: rtl/evt_xfer_chan.sv
module evt_xfer_chan
  import evt_xfer_pkg::*;
#(
  parameter int SEG_W = 8,
  parameter int OFS_W = 16,
  localparam int AW = SEG_W + OFS_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [2:0]    cfgSel,
  input  logic [15:0]   cfgData,
  input  logic          srvReq,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [1:0]    memByteEn,
  output logic [15:0]   memWdata,
  input  logic [15:0]   memRdata,
  input  logic          memAck,
  output logic          busy,
  output logic          intReq,
  output logic          eotOwn,
  output logic          eotSep,
  output logic          linkEn,
  output logic [1:0]    prioLevel,
  output logic [15:0]   ctrlWord,
  output logic [AW-1:0] srcAddr,
  output logic [AW-1:0] dstAddr
);

  xferStrobe_t strb;
  logic        cntZero, cntOne;

  evt_xfer_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .srvReq(srvReq), .memAck(memAck),
    .cntZero(cntZero), .cntOne(cntOne), .eopSel(ctrlWord[BIT_EOP]),
    .strb(strb), .memReq(memReq), .memWe(memWe), .busy(busy),
    .intReq(intReq), .eotOwn(eotOwn), .eotSep(eotSep)
  );

  evt_xfer_dp #(.SEG_W(SEG_W), .OFS_W(OFS_W)) uDp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .strb(strb), .memRdata(memRdata), .ctrlWord(ctrlWord),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .memAddr(memAddr),
    .memWdata(memWdata), .memByteEn(memByteEn),
    .cntZero(cntZero), .cntOne(cntOne)
  );

  assign linkEn    = ctrlWord[BIT_LINK];
  assign prioLevel = ctrlWord[BIT_PRI0+1:BIT_PRI0];

endmodule

// File: rtl/evt_xfer_chk.sv
module evt_xfer_chk #(
  parameter int SEG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWe,
  input logic             memReq,
  input logic             memWe,
  input logic             memAck,
  input logic             addrLsb,
  input logic [1:0]       memByteEn,
  input logic             busy,
  input logic             intReq,
  input logic             eotOwn,
  input logic             eotSep,
  input logic [7:0]       cnt,
  input logic             byteMode,
  input logic             eopSel,
  input logic [SEG_W-1:0] srcSeg,
  input logic [SEG_W-1:0] dstSeg
);

  assert_word_lanes_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !byteMode |-> memByteEn == 2'b11 && !addrLsb);

  assert_byte_lane_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReq && byteMode |-> $countones(memByteEn) == 1 && memByteEn[1] == addrLsb);

  assert_seg_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |=> $stable(srcSeg) && $stable(dstSeg));

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && memAck && !cfgWe |=> cnt == $past(cnt) - 8'd1);

  assert_eot_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(eotOwn && eotSep));

  assert_eot_route_R8: assert property (@(posedge clk) disable iff (!rstN)
    eotSep |-> $past(eopSel));

  assert_int_pass_R9: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> $past(cnt) == 8'd0 && !busy);

  assert_read_first_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !memWe);

  assert_busy_release_R10: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && memAck |=> !busy);

endmodule

bind evt_xfer_chan evt_xfer_chk #(.SEG_W(SEG_W)) uChk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .memReq(memReq), .memWe(memWe),
  .memAck(memAck), .addrLsb(memAddr[0]), .memByteEn(memByteEn), .busy(busy),
  .intReq(intReq), .eotOwn(eotOwn), .eotSep(eotSep), .cnt(ctrlWord[7:0]),
  .byteMode(ctrlWord[8]), .eopSel(ctrlWord[14]),
  .srcSeg(srcAddr[SEG_W+OFS_W-1:OFS_W]), .dstSeg(dstAddr[SEG_W+OFS_W-1:OFS_W])
);

// File: tb/sim_evt_xfer_chan.sv
`timescale 1ns/100ps
module sim_evt_xfer_chan;

  localparam int SEG_W = 4;
  localparam int OFS_W = 16;
  localparam int AW = SEG_W + OFS_W;
  localparam logic [SEG_W-1:0] SSEG = 4'd3;
  localparam logic [SEG_W-1:0] DSEG = 4'd5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWe = 1'b0;
  logic [2:0]    cfgSel = '0;
  logic [15:0]   cfgData = '0;
  logic          srvReq = 1'b0;
  logic          memReq, memWe;
  logic [AW-1:0] memAddr;
  logic [1:0]    memByteEn;
  logic [15:0]   memWdata, memRdata;
  logic          memAck = 1'b0;
  logic          busy, intReq, eotOwn, eotSep, linkEn;
  logic [1:0]    prioLevel;
  logic [15:0]   ctrlWord;
  logic [AW-1:0] srcAddr, dstAddr;

  int nChk = 0, nFail = 0;
  int wrCnt = 0, rdCnt = 0, eotOwnCnt = 0, eotSepCnt = 0, intCnt = 0;
  logic [AW-1:0] lastWrAddr = '0;
  logic [15:0]   lastWrData = '0;
  logic [1:0]    lastWrBe = '0;

  always #2.5 clk = ~clk;

  evt_xfer_chan #(.SEG_W(SEG_W), .OFS_W(OFS_W)) u0 (.*);

  function automatic logic [15:0] patWord(logic [AW-1:0] a);
    return {a[7:0] ^ 8'hA5, a[7:0] ^ 8'h3C};
  endfunction

  assign memRdata = patWord({memAddr[AW-1:1], 1'b0});

  always @(posedge clk) begin
    memAck <= memReq && !memAck;
    if (memReq && memAck && memWe) begin
      wrCnt <= wrCnt + 1;
      lastWrAddr <= memAddr;
      lastWrData <= memWdata;
      lastWrBe <= memByteEn;
    end
    if (memReq && memAck && !memWe) rdCnt <= rdCnt + 1;
    if (eotOwn) eotOwnCnt <= eotOwnCnt + 1;
    if (eotSep) eotSepCnt <= eotSepCnt + 1;
    if (intReq) intCnt <= intCnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk); cfgWe = 1'b1; cfgSel = sel; cfgData = d;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  task automatic fire();
    @(negedge clk); srvReq = 1'b1;
    @(negedge clk); srvReq = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  // {ctrl, srcOfs, dstOfs, expSrcOfs, expDstOfs}
  localparam logic [79:0] VEC [7] = '{
    {16'h0601, 16'h1000, 16'h2000, 16'h1002, 16'h2002},
    {16'h4301, 16'h1001, 16'h2000, 16'h1001, 16'h2001},
    {16'h0501, 16'h1003, 16'h2001, 16'h1004, 16'h2001},
    {16'h0001, 16'h1234, 16'h4320, 16'h1234, 16'h4320},
    {16'h0601, 16'hFFFE, 16'hFFFF, 16'h0000, 16'h0001},
    {16'h4701, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000},
    {16'h7C01, 16'h00FF, 16'h0100, 16'h0101, 16'h0100}
  };

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", 32'(ctrlWord), 0);
    chk("R1 src", 32'(srcAddr), 0);
    chk("R1 dst", 32'(dstAddr), 0);
    chk("R1 quiet", {busy, memReq, intReq, eotOwn, eotSep}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R12 segment writes take low bits only
    cfgWrite(3'd3, 16'hFFF3);
    cfgWrite(3'd4, 16'h0005);
    chk("R12 src seg", 32'(srcAddr[AW-1:OFS_W]), 32'(SSEG));
    chk("R12 dst seg", 32'(dstAddr[AW-1:OFS_W]), 32'(DSEG));
    cfgWrite(3'd0, 16'h8012);
    chk("R12 ctrl bit15 zero", 32'(ctrlWord), 32'h0012);

    // table walk: R2 R3 R4 R5 R6 R8
    for (int i = 0; i < 7; i++) begin
      logic [15:0] c, s, d, es, ed, w, expData;
      logic [7:0] b;
      logic bm;
      logic [AW-1:0] expAddr;
      logic [1:0] expBe;
      int o0, s0;
      {c, s, d, es, ed} = VEC[i];
      cfgWrite(3'd0, c);
      cfgWrite(3'd1, s);
      cfgWrite(3'd2, d);
      o0 = eotOwnCnt; s0 = eotSepCnt;
      fire();
      bm = c[8];
      w = patWord({SSEG, s[15:1], 1'b0});
      b = s[0] ? w[15:8] : w[7:0];
      expData = bm ? {b, b} : w;
      expAddr = bm ? {DSEG, d} : {DSEG, d[15:1], 1'b0};
      expBe = !bm ? 2'b11 : (d[0] ? 2'b10 : 2'b01);
      chk(bm ? "R3 data" : "R2 data", 32'(lastWrData), 32'(expData));
      chk(bm ? "R3 addr" : "R2 addr", 32'(lastWrAddr), 32'(expAddr));
      chk(bm ? "R3 lanes" : "R2 lanes", 32'(lastWrBe), 32'(expBe));
      chk("R4 R5 R6 src", 32'(srcAddr), 32'({SSEG, es}));
      chk("R4 R5 R6 dst", 32'(dstAddr), 32'({DSEG, ed}));
      chk("R7 count", 32'(ctrlWord[7:0]), 0);
      chk("R8 own", eotOwnCnt - o0, c[14] ? 0 : 1);
      chk("R8 sep", eotSepCnt - s0, c[14] ? 1 : 0);
    end
    // R11 from last vector (ctrl 0x7C01)
    chk("R11 link", 32'(linkEn), 1);
    chk("R11 prio", 32'(prioLevel), 3);

    // R9 count zero request
    begin
      int r0, w0, i0;
      logic [AW-1:0] sa, da;
      r0 = rdCnt; w0 = wrCnt; i0 = intCnt; sa = srcAddr; da = dstAddr;
      fire();
      chk("R9 no read", rdCnt - r0, 0);
      chk("R9 no write", wrCnt - w0, 0);
      chk("R9 int one cycle", intCnt - i0, 1);
      chk("R9 src kept", 32'(srcAddr), 32'(sa));
      chk("R9 dst kept", 32'(dstAddr), 32'(da));
    end

    // R7 R8 multi-count block, no end pulse until zero
    cfgWrite(3'd0, 16'h0603);
    cfgWrite(3'd1, 16'h0100);
    cfgWrite(3'd2, 16'h0200);
    for (int k = 1; k <= 3; k++) begin
      int o0;
      o0 = eotOwnCnt;
      fire();
      chk("R7 count down", 32'(ctrlWord[7:0]), 32'(3 - k));
      chk("R5 word step", 32'(srcAddr[15:0]), 32'(16'h0100 + 2 * k));
      chk("R8 pulse at zero", eotOwnCnt - o0, (k == 3) ? 1 : 0);
    end

    // R10 busy and ignored request
    cfgWrite(3'd0, 16'h0005);
    begin
      int w0;
      w0 = wrCnt;
      @(negedge clk); srvReq = 1'b1;
      @(negedge clk);
      chk("R10 busy", 32'(busy), 1);
      srvReq = 1'b1;
      @(negedge clk); srvReq = 1'b0;
      repeat (14) @(negedge clk);
      chk("R10 one transfer", wrCnt - w0, 1);
      chk("R10 count", 32'(ctrlWord[7:0]), 4);
      chk("R10 idle", 32'(busy), 0);
    end

    summary();
  end

endmodule